// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives the scan of a raster panel. It keeps a horizontal position counter and a vertical line counter that advance on a pixel-clock enable. From those counters it produces horizontal sync, vertical sync, a data-enable and one-cycle strobes at the last position of each line and each frame. Every sync window and active window is a start/end pair of 16-bit positions packed into one 32-bit register. The line length and the frame length come from a single total register.

A mode input picks one of four panel styles. In the TFT and single-panel STN styles the programmed values are used as written. In the dual-panel STN style the vertical active window covers half of its programmed span. In the 8-bit serial style every pixel takes three clocks, so the horizontal active span is tripled and the line is extended to match. Register writes and mode changes go to shadow copies, and those copies are loaded only when a new frame begins. A halt request is held until the end of the current frame. At that point the block stops and reports that it is stopped.

Top module: `disp_tgen`

## Requirements
- R1: After reset the block is stopped (`stopped`=1), both counters read 0, and `hsync`, `vsync`, `de`, `line_end` and `frame_end` are low.
- R2: Writes use word addresses. 1 is the total register, with the line total in [31:16] and the frame total in [15:0]. 2 is the hsync window, 3 the vsync window, 4 the horizontal active window and 5 the vertical active window. Each window holds its start in [31:16] and its end in [15:0]. 0 is control: bit 3 starts the block, and bit 4 requests a halt.
- R3: While running, `pos_x` advances by one on each cycle with `pix_ce` high and wraps to 0 after the last position of the line. At that wrap `pos_y` advances, and it wraps to 0 after the last line. With `pix_ce` low both counters hold. Starting always begins at position 0 of line 0.
- R4: Each window output is high when start <= counter < end. `de` is high when the position lies in both active windows.
- R5: `line_end` is high on a cycle with `pix_ce` high at the last position of a line. `frame_end` is high when `line_end` is high on the last line. Each counter reads 0 in the cycle after its own wrap.
- R6: With mode 3 (serial), the horizontal active end becomes start + 3*(end-start). The line total grows by 2*(end-start).
- R7: With mode 2 (dual-panel STN), the vertical active end becomes start + floor((end-start)/2). Modes 0 (TFT) and 1 (single-panel STN) use the windows unchanged.
- R8: While running, window writes, total writes and mode changes take effect from the first cycle of the next frame. While stopped they take effect at once.
- R9: A halt request takes effect at the edge that ends the current frame. A control write with bit 3 set clears a pending halt, so the block keeps running past the frame end.
- R10: While stopped, both counters stay at 0 and all sync, enable and strobe outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-clock enable; counters advance only when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register word address |
| wr_data | input | DW | Register write data |
| mode | input | 2 | Panel style: 0 TFT, 1 STN single, 2 STN dual, 3 serial |
| hsync | output | 1 | Horizontal sync window |
| vsync | output | 1 | Vertical sync window |
| de | output | 1 | Active-area data enable |
| line_end | output | 1 | Last position of a line strobe |
| frame_end | output | 1 | Last position of a frame strobe |
| pos_x | output | CW+2 | Horizontal position counter |
| pos_y | output | CW | Vertical line counter |
| stopped | output | 1 | Block is halted |

## Verification
The counters, the run flag and the shadow copies are the only registers on the output path. All outputs are decoded combinationally from them. A control write that starts the block therefore shows position 0 of line 0 in the next cycle. `line_end` and `frame_end` follow `pix_ce` in the same cycle, and a halt shows as `stopped` in the cycle after the `frame_end` strobe. The bench drives each stimulus at the falling edge and compares all outputs 1 ns later, before the next rising edge. After each rising edge it advances a reference model derived from the requirements, so every comparison lines up with the cycle in which the registered state is due.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;

  typedef enum logic [1:0] {
    MODE_TFT     = 2'd0,
    MODE_STN_ONE = 2'd1,
    MODE_STN_TWO = 2'd2,
    MODE_SER3    = 2'd3
  } tg_mode_e;

  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_TOTAL    = 1;
  localparam int ADDR_WIN0     = 2;
  localparam int NUM_WIN       = 4;
  localparam int WIN_HS        = 0;
  localparam int WIN_VS        = 1;
  localparam int WIN_HA        = 2;
  localparam int WIN_VA        = 3;
  localparam int CTRL_RUN_BIT  = 3;
  localparam int CTRL_HALT_BIT = 4;

endpackage

// File: rtl/disp_tgen_regs.sv
module disp_tgen_regs
  import disp_tgen_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] tot_h,
  output logic [CW-1:0] tot_v,
  output logic [CW-1:0] win_lo [NUM_WIN],
  output logic [CW-1:0] win_hi [NUM_WIN],
  output logic          run_req,
  output logic          halt_pend
);
  localparam int HALF = DW / 2;

  logic ctrl_sel;
  assign ctrl_sel = wr_en && (wr_addr == AW'(ADDR_CTRL));
  assign run_req  = ctrl_sel && wr_data[CTRL_RUN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_pend <= 1'b0;
    end else if (ctrl_sel) begin
      if (wr_data[CTRL_RUN_BIT])       halt_pend <= 1'b0;
      else if (wr_data[CTRL_HALT_BIT]) halt_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tot_h <= '0;
      tot_v <= '0;
    end else if (wr_en && (wr_addr == AW'(ADDR_TOTAL))) begin
      tot_h <= wr_data[HALF +: CW];
      tot_v <= wr_data[0 +: CW];
    end
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_lo[gi] <= '0;
        win_hi[gi] <= '0;
      end else if (wr_en && (wr_addr == AW'(ADDR_WIN0 + gi))) begin
        win_lo[gi] <= wr_data[HALF +: CW];
        win_hi[gi] <= wr_data[0 +: CW];
      end
    end
  end

endmodule

// File: rtl/disp_tgen_scan.sv
module disp_tgen_scan #(
  parameter int XW = 18,
  parameter int YW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ce,
  input  logic [XW-1:0] len_h,
  input  logic [YW-1:0] len_v,
  output logic [XW-1:0] pos_h,
  output logic [YW-1:0] pos_v,
  output logic          line_end,
  output logic          frame_end
);
  logic last_h, last_v;
  assign last_h = ({1'b0, pos_h} + (XW+1)'(1)) >= {1'b0, len_h};
  assign last_v = ({1'b0, pos_v} + (YW+1)'(1)) >= {1'b0, len_v};

  assign line_end  = run && ce && last_h;
  assign frame_end = line_end && last_v;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pos_h <= '0;
      pos_v <= '0;
    end else if (ce) begin
      if (last_h) begin
        pos_h <= '0;
        pos_v <= last_v ? '0 : pos_v + YW'(1);
      end else begin
        pos_h <= pos_h + XW'(1);
      end
    end
  end

endmodule

// File: rtl/disp_tgen_win.sv
module disp_tgen_win #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic         hit
);
  assign hit = (cnt >= lo) && (cnt < hi);
endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import disp_tgen_pkg::*;
#(
  parameter  int CW = 16,
  parameter  int DW = 32,
  parameter  int AW = 3,
  localparam int XW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    mode,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          line_end,
  output logic          frame_end,
  output logic [XW-1:0] pos_x,
  output logic [CW-1:0] pos_y,
  output logic          stopped
);

  function automatic logic [XW-1:0] span_of(logic [CW-1:0] lo, logic [CW-1:0] hi);
    return (hi > lo) ? XW'(hi - lo) : '0;
  endfunction

  function automatic logic [XW-1:0] tripled_end(logic [CW-1:0] lo, logic [CW-1:0] hi);
    return XW'(lo) + (span_of(lo, hi) << 1) + span_of(lo, hi);
  endfunction

  function automatic logic [XW-1:0] stretched_total(logic [CW-1:0] tot, logic [CW-1:0] lo,
                                                    logic [CW-1:0] hi);
    return XW'(tot) + (span_of(lo, hi) << 1);
  endfunction

  function automatic logic [CW-1:0] halved_end(logic [CW-1:0] lo, logic [CW-1:0] hi);
    return lo + CW'(span_of(lo, hi) >> 1);
  endfunction

  logic [CW-1:0] tot_h, tot_v;
  logic [CW-1:0] win_lo [NUM_WIN];
  logic [CW-1:0] win_hi [NUM_WIN];
  logic          run_req, halt_pend;

  disp_tgen_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tot_h(tot_h), .tot_v(tot_v), .win_lo(win_lo), .win_hi(win_hi),
    .run_req(run_req), .halt_pend(halt_pend)
  );

  tg_mode_e md;
  assign md = tg_mode_e'(mode);

  // next shadow values, effective geometry per mode
  logic [XW-1:0] nx_tot_h, nx_ha_hi;
  logic [CW-1:0] nx_va_hi;
  always_comb begin
    nx_tot_h = XW'(tot_h);
    nx_ha_hi = XW'(win_hi[WIN_HA]);
    nx_va_hi = win_hi[WIN_VA];
    if (md == MODE_SER3) begin
      nx_tot_h = stretched_total(tot_h, win_lo[WIN_HA], win_hi[WIN_HA]);
      nx_ha_hi = tripled_end(win_lo[WIN_HA], win_hi[WIN_HA]);
    end
    if (md == MODE_STN_TWO) nx_va_hi = halved_end(win_lo[WIN_VA], win_hi[WIN_VA]);
  end

  // run control; internal events are named for the checker
  logic running, go_now, halt_now, load_now;
  assign go_now   = !running && run_req;
  assign halt_now = frame_end && halt_pend && !run_req;
  assign load_now = !running || frame_end;

  always_ff @(posedge clk) begin
    if (!rst_n)        running <= 1'b0;
    else if (go_now)   running <= 1'b1;
    else if (halt_now) running <= 1'b0;
  end
  assign stopped = !running;

  logic [XW-1:0] sh_tot_h, sh_hs_lo, sh_hs_hi, sh_ha_lo, sh_ha_hi;
  logic [CW-1:0] sh_tot_v, sh_vs_lo, sh_vs_hi, sh_va_lo, sh_va_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_tot_h <= '0; sh_hs_lo <= '0; sh_hs_hi <= '0; sh_ha_lo <= '0; sh_ha_hi <= '0;
      sh_tot_v <= '0; sh_vs_lo <= '0; sh_vs_hi <= '0; sh_va_lo <= '0; sh_va_hi <= '0;
    end else if (load_now) begin
      sh_tot_h <= nx_tot_h;
      sh_hs_lo <= XW'(win_lo[WIN_HS]);
      sh_hs_hi <= XW'(win_hi[WIN_HS]);
      sh_ha_lo <= XW'(win_lo[WIN_HA]);
      sh_ha_hi <= nx_ha_hi;
      sh_tot_v <= tot_v;
      sh_vs_lo <= win_lo[WIN_VS];
      sh_vs_hi <= win_hi[WIN_VS];
      sh_va_lo <= win_lo[WIN_VA];
      sh_va_hi <= nx_va_hi;
    end
  end

  disp_tgen_scan #(.XW(XW), .YW(CW)) u_scan (
    .clk(clk), .rst_n(rst_n), .run(running), .ce(pix_ce),
    .len_h(sh_tot_h), .len_v(sh_tot_v), .pos_h(pos_x), .pos_v(pos_y),
    .line_end(line_end), .frame_end(frame_end)
  );

  logic hs_hit, vs_hit, ha_hit, va_hit;
  disp_tgen_win #(.W(XW)) u_hs (.cnt(pos_x), .lo(sh_hs_lo), .hi(sh_hs_hi), .hit(hs_hit));
  disp_tgen_win #(.W(CW)) u_vs (.cnt(pos_y), .lo(sh_vs_lo), .hi(sh_vs_hi), .hit(vs_hit));
  disp_tgen_win #(.W(XW)) u_ha (.cnt(pos_x), .lo(sh_ha_lo), .hi(sh_ha_hi), .hit(ha_hit));
  disp_tgen_win #(.W(CW)) u_va (.cnt(pos_y), .lo(sh_va_lo), .hi(sh_va_hi), .hit(va_hit));

  assign hsync = running && hs_hit;
  assign vsync = running && vs_hit;
  assign de    = running && ha_hit && va_hit;

endmodule

// File: rtl/disp_tgen_chk.sv
module disp_tgen_chk #(
  parameter int XW = 18,
  parameter int YW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ce,
  input logic          stopped,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          line_end,
  input logic          frame_end,
  input logic [XW-1:0] pos_x,
  input logic [YW-1:0] pos_y
);

  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!hsync && !vsync && !de && !line_end && !frame_end && pos_x == '0 && pos_y == '0));

  p_frame_in_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> line_end);

  p_line_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (pos_x == '0));

  p_frame_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pos_y == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && pix_ce && !line_end) |=> (pos_x == $past(pos_x) + XW'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !pix_ce) |=> ($stable(pos_x) && $stable(pos_y)));

  p_stop_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !frame_end) |=> !stopped);

  p_start_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopped) |-> (pos_x == '0 && pos_y == '0));

endmodule

bind disp_tgen disp_tgen_chk #(.XW(XW), .YW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .stopped(stopped),
  .hsync(hsync), .vsync(vsync), .de(de), .line_end(line_end), .frame_end(frame_end),
  .pos_x(pos_x), .pos_y(pos_y)
);

// File: tb/disp_tgen_test.sv
module disp_tgen_test;
  localparam int CW = 16;
  localparam int XW = CW + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        s_ce = 1'b1, s_wr = 1'b0;
  logic [2:0]  s_addr = '0;
  logic [31:0] s_data = '0;
  logic [1:0]  s_mode = '0;

  logic hsync, vsync, de, line_end, frame_end, stopped;
  logic [XW-1:0] pos_x;
  logic [CW-1:0] pos_y;

  disp_tgen uut (
    .clk(clk), .rst_n(rst_n), .pix_ce(s_ce), .wr_en(s_wr), .wr_addr(s_addr),
    .wr_data(s_data), .mode(s_mode), .hsync(hsync), .vsync(vsync), .de(de),
    .line_end(line_end), .frame_end(frame_end), .pos_x(pos_x), .pos_y(pos_y),
    .stopped(stopped)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state: programmed (p_) and frame-active (c_) values
  int m_run = 0, m_h = 0, m_v = 0, m_pend = 0;
  int p_th = 0, p_tv = 0, c_th = 0, c_tv = 0, c_md = 0;
  int p_lo[4] = '{0, 0, 0, 0};
  int p_hi[4] = '{0, 0, 0, 0};
  int c_lo[4] = '{0, 0, 0, 0};
  int c_hi[4] = '{0, 0, 0, 0};

  function automatic int width_of(int i);
    return (c_hi[i] > c_lo[i]) ? c_hi[i] - c_lo[i] : 0;
  endfunction
  // serial: each active pixel costs three clocks, extra clocks extend the line
  function automatic int line_len();
    return (c_md == 3) ? c_th + 2 * width_of(2) : c_th;
  endfunction
  function automatic int ha_end();
    return (c_md == 3) ? c_lo[2] + 3 * width_of(2) : c_hi[2];
  endfunction
  // dual panel: half the programmed active lines
  function automatic int va_end();
    return (c_md == 2) ? c_lo[3] + width_of(3) / 2 : c_hi[3];
  endfunction
  function automatic bit inside_w(int p, int lo, int hi);
    return (p >= lo) && (p < hi);
  endfunction
  function automatic int frame_cycles();
    return line_len() * c_tv;
  endfunction

  task automatic load_cur();
    c_th = p_th; c_tv = p_tv; c_md = int'(s_mode);
    for (int i = 0; i < 4; i++) begin c_lo[i] = p_lo[i]; c_hi[i] = p_hi[i]; end
  endtask

  // compare at current cycle, then advance the model over the next rising edge
  task automatic tick(string tag);
    logic [39:0] act, exp;
    bit ell, eo, en_w, dis_w;
    #1;
    ell = (m_run != 0) && s_ce && (m_h == line_len() - 1);
    eo  = ell && (m_v == c_tv - 1);
    if (m_run == 0) exp = {1'b1, 5'b0, 18'd0, 16'd0};
    else exp = {1'b0, inside_w(m_h, c_lo[0], c_hi[0]), inside_w(m_v, c_lo[1], c_hi[1]),
                inside_w(m_h, c_lo[2], ha_end()) && inside_w(m_v, c_lo[3], va_end()),
                ell, eo, 18'(m_h), 16'(m_v)};
    act = {stopped, hsync, vsync, de, line_end, frame_end, pos_x, pos_y};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (h=%0d v=%0d)", tag, act, exp, m_h, m_v);
    end
    en_w  = s_wr && (s_addr == 3'd0) && s_data[3];
    dis_w = s_wr && (s_addr == 3'd0) && !s_data[3] && s_data[4];
    @(posedge clk);
    if (m_run == 0) begin
      load_cur(); m_h = 0; m_v = 0;
      if (en_w) m_run = 1;
    end else if (eo && (m_pend != 0) && !en_w) begin
      load_cur(); m_run = 0; m_h = 0; m_v = 0;
    end else if (s_ce) begin
      if (eo) begin load_cur(); m_h = 0; m_v = 0; end
      else if (ell) begin m_h = 0; m_v++; end
      else m_h++;
    end
    if (en_w) m_pend = 0;
    else if (dis_w) m_pend = 1;
    if (s_wr) begin
      if (s_addr == 3'd1) begin p_th = int'(s_data[31:16]); p_tv = int'(s_data[15:0]); end
      else if (s_addr >= 3'd2 && s_addr <= 3'd5) begin
        p_lo[s_addr-2] = int'(s_data[31:16]);
        p_hi[s_addr-2] = int'(s_data[15:0]);
      end
    end
    @(negedge clk);
  endtask

  task automatic put(input logic [2:0] a, input logic [31:0] d, string tag);
    s_wr = 1'b1; s_addr = a; s_data = d;
    tick(tag);
    s_wr = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic cfg(int th, int tv, int hl, int hh, int vl, int vh, int al, int ah,
                     int bl, int bh);
    put(3'd1, {16'(th), 16'(tv)}, "R2 total");
    put(3'd2, {16'(hl), 16'(hh)}, "R2 hsync");
    put(3'd3, {16'(vl), 16'(vh)}, "R2 vsync");
    put(3'd4, {16'(al), 16'(ah)}, "R2 hact");
    put(3'd5, {16'(bl), 16'(bh)}, "R2 vact");
  endtask

  task automatic halt_and_wait(string tag);
    put(3'd0, 32'h10, tag);
    idle(frame_cycles() + 3, tag);
  endtask

  task automatic t_reset();
    idle(4, "R1 R10 reset state");
  endtask

  task automatic t_tft();
    s_mode = 2'd0;
    cfg(12, 6, 0, 2, 0, 1, 4, 10, 2, 5);
    idle(2, "R10 stopped after config");
    put(3'd0, 32'h8, "R3 start");
    idle(12 * 6 * 2, "R3 R4 R5 TFT frames");
    halt_and_wait("R9 halt at frame end");
  endtask

  task automatic t_stn_single();
    s_mode = 2'd1;
    cfg(14, 5, 8, 11, 0, 1, 1, 8, 0, 4);
    put(3'd0, 32'h8, "R7 start single");
    idle(14 * 5 * 2, "R4 R7 STN single frames");
    halt_and_wait("R9 halt single");
  endtask

  task automatic t_serial();
    s_mode = 2'd3;
    cfg(12, 4, 0, 2, 0, 1, 3, 6, 1, 3);
    put(3'd0, 32'h8, "R6 start serial");
    idle(18 * 4 * 2, "R6 serial frames");
    halt_and_wait("R9 halt serial");
  endtask

  task automatic t_dual();
    s_mode = 2'd2;
    cfg(10, 8, 0, 1, 0, 1, 2, 8, 1, 6);
    put(3'd0, 32'h8, "R7 start dual");
    idle(10 * 8 * 2, "R7 dual frames");
    halt_and_wait("R9 halt dual");
  endtask

  task automatic t_shadow();
    s_mode = 2'd0;
    cfg(12, 5, 0, 2, 0, 1, 4, 10, 1, 4);
    put(3'd0, 32'h8, "R8 start");
    idle(20, "R8 before write");
    put(3'd4, {16'd3, 16'd7}, "R8 hact write mid frame");
    put(3'd2, {16'd9, 16'd11}, "R8 hsync write mid frame");
    s_mode = 2'd3;
    idle(12 * 5 - 22, "R8 old frame keeps old geometry");
    idle(20 * 5 + 4, "R8 new frame uses new geometry");
    s_mode = 2'd0;
    halt_and_wait("R9 halt shadow");
  endtask

  task automatic t_ce_gate();
    s_mode = 2'd0;
    cfg(8, 3, 0, 1, 0, 1, 2, 6, 0, 2);
    put(3'd0, 32'h8, "R3 start gated");
    for (int i = 0; i < 120; i++) begin
      s_ce = (i % 3) != 0;
      tick("R3 R5 pixel enable gating");
    end
    s_ce = 1'b1;
    halt_and_wait("R9 halt gated");
  endtask

  task automatic t_cancel();
    s_mode = 2'd0;
    cfg(9, 3, 0, 1, 0, 1, 1, 8, 0, 3);
    put(3'd0, 32'h8, "R9 start cancel");
    idle(5, "R9 running");
    put(3'd0, 32'h10, "R9 halt request");
    idle(4, "R9 pending");
    put(3'd0, 32'h8, "R9 restart clears pending");
    idle(9 * 3 * 2, "R9 continues past frame end");
    halt_and_wait("R9 final halt");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tft();
    t_stn_single();
    t_serial();
    t_dual();
    t_shadow();
    t_ce_gate();
    t_cancel();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule